// File: doc/BRIEF.md
# Request Target Decoder for a Coherent Network

This block lives inside a requesting agent on a layered coherent on-chip network. Every outgoing request must name the network node that will serve it, and must carry the sender's own ID so that the answer can find its way back. Given a request strobe, a message class and a physical address, the decoder returns the destination node ID and the source ID one clock later.

Routing happens in two stages. First, the message class is checked: DVM and barrier traffic always goes to the single miscellaneous node. Second, ordinary memory traffic is matched against a small set of prioritised address windows. A window is marked either as fully coherent storage or as belonging to a particular I/O-coherent home node. For fully coherent windows, an XOR-fold hash of the cache-line address picks a partition number. The width of that hash follows the configured partition count. A lookup table then turns the partition number into a node ID. Addresses that fall into no enabled window go to I/O home node 0.

All window, count and ID-table inputs are static configuration. They may only change while no request is being presented.

Top module: `tgt_route_dec`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `out_vld`, `tgt_id` and `src_id` are cleared to zero.
- R2: `out_vld` is high in exactly the cycle after a cycle in which `req_vld` was high at the clock edge, and low otherwise; back-to-back requests produce back-to-back results.
- R3: When `req_vld` is low at a clock edge, `tgt_id` and `src_id` keep their previous values, whatever the address, class or own-ID inputs do.
- R4: A request whose `req_cls` is not 0 is routed to `mn_id`, regardless of address and window settings. The encodings are 0 = memory, 1 = DVM, 2 = barrier, 3 = reserved.
- R5: A memory request (`req_cls` = 0) that lands in a fully coherent window (`rgn_fc` bit = 1) is routed to entry P of `hnf_id_tbl`, where P is the partition hash of R6 and entry P occupies bits [P*NODE_W +: NODE_W].
- R6: The partition hash works on the line address `req_addr[ADDR_W-1:6]` for a count of 2^`hnf_lg` partitions. Bit j of P is the XOR of every line-address bit i with i mod `hnf_lg` = j. When `hnf_lg` = 0, P is 0. Address bits [5:0] never affect P.
- R7: Window k matches when `rgn_en[k]` is 1 and `((req_addr ^ base_k) & mask_k) == 0`, where base_k and mask_k are slices [k*ADDR_W +: ADDR_W] of `rgn_base` and `rgn_mask`. When several windows match, the lowest-numbered one decides the route.
- R8: A memory request whose deciding window has `rgn_fc` bit = 0 is routed to entry `rgn_io_sel` slice k of `hni_id_tbl`, where the selector occupies bits [k*IO_W +: IO_W].
- R9: A memory request that matches no enabled window is routed to entry 0 of `hni_id_tbl`.
- R10: `src_id` takes the value of `own_id` that was present in the cycle the request was accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_vld | input | 1 | Request present this cycle |
| req_cls | input | 2 | Message class: 0 memory, 1 DVM, 2 barrier, 3 reserved |
| req_addr | input | ADDR_W | Physical address of the request |
| own_id | input | NODE_W | Network ID of this requesting node |
| rgn_base | input | NUM_REG*ADDR_W | Base address of each window |
| rgn_mask | input | NUM_REG*ADDR_W | Bits compared for each window (1 = compared) |
| rgn_en | input | NUM_REG | Window enable bits |
| rgn_fc | input | NUM_REG | 1 = window is fully coherent, 0 = I/O coherent |
| rgn_io_sel | input | NUM_REG*IO_W | I/O home-node index per window |
| hnf_lg | input | LG_W | log2 of the fully coherent partition count |
| hnf_id_tbl | input | 2^PART_W*NODE_W | Node ID for each partition number |
| hni_id_tbl | input | NUM_HNI*NODE_W | Node ID for each I/O home node |
| mn_id | input | NODE_W | Node ID of the miscellaneous node |
| out_vld | output | 1 | Decoded route valid |
| tgt_id | output | NODE_W | Destination node ID |
| src_id | output | NODE_W | Source node ID sent with the request |

## Verification
The bench builds the decoder with a 16-bit address, 6-bit node IDs, four windows, two I/O home nodes and up to eight partitions. With those settings the line address is only 10 bits wide, so the fold hash is swept over every line address for every partition count from 1 to 8, with varying offset bits. The smaller address space also makes it practical to step through the whole address range against a window set with overlaps, a shadowed window and a disabled window, which exercises priority and the default route. Class overrides, back-to-back issue, holding while idle and the capture of the own ID are covered with directed sequences.

// File: rtl/tgt_route_pkg.sv
// Shared definitions for the request target decoder.
// Assumes a 64-byte cache line: the partition hash ignores the offset bits.
package tgt_route_pkg;

    // Message classes carried with each request
    typedef enum logic [1:0] {
        CLS_MEM = 2'd0,
        CLS_DVM = 2'd1,
        CLS_BAR = 2'd2,
        CLS_RSV = 2'd3
    } req_cls_e;

    // Number of byte-offset bits inside one cache line
    localparam int LINE_OFS = 6;

endpackage

// File: rtl/tgt_fold_hash.sv
// Partition hash: XOR-folds a cache-line address down to hnf_lg bits.
// Every fold width from 1 to PART_W is built in parallel, and hnf_lg picks one.
// Assumes hnf_lg <= PART_W. A value of 0 yields partition 0.
module tgt_fold_hash #(
    parameter int LINE_W = 42,
    parameter int PART_W = 3,
    parameter int LG_W   = 2
) (
    input  logic [LINE_W-1:0] line_addr,
    input  logic [LG_W-1:0]   hnf_lg,
    output logic [PART_W-1:0] part
);

    localparam int NUM_FOLD = PART_W + 1;

    logic [NUM_FOLD*PART_W-1:0] fold_flat;

    assign fold_flat[PART_W-1:0] = '0;

    for (genvar k = 1; k <= PART_W; k++) begin : g_fold
        logic [PART_W-1:0] f;
        // Fold line-address bit i onto result bit (i mod k)
        always_comb begin
            f = '0;
            for (int i = 0; i < LINE_W; i++) begin
                f[i % k] = f[i % k] ^ line_addr[i];
            end
        end
        assign fold_flat[k*PART_W +: PART_W] = f;
    end

    // Select the fold that matches the configured partition count
    always_comb begin
        part = fold_flat[int'(hnf_lg)*PART_W +: PART_W];
    end

endmodule

// File: rtl/tgt_rgn_match.sv
// Address window matcher with fixed priority (lowest index wins).
// A window matches when it is enabled and the address equals its base on
// every bit set in its mask. Reports the winner's coherency kind and its
// I/O home-node selector.
module tgt_rgn_match #(
    parameter int ADDR_W  = 48,
    parameter int NUM_REG = 8,
    parameter int IO_W    = 2
) (
    input  logic [ADDR_W-1:0]         addr,
    input  logic [NUM_REG*ADDR_W-1:0] rgn_base,
    input  logic [NUM_REG*ADDR_W-1:0] rgn_mask,
    input  logic [NUM_REG-1:0]        rgn_en,
    input  logic [NUM_REG-1:0]        rgn_fc,
    input  logic [NUM_REG*IO_W-1:0]   rgn_io_sel,
    output logic                      hit,
    output logic                      hit_fc,
    output logic [IO_W-1:0]           hit_io
);

    logic [NUM_REG-1:0] m;

    for (genvar r = 0; r < NUM_REG; r++) begin : g_cmp
        // Per-window masked compare
        assign m[r] = rgn_en[r] &&
            (((addr ^ rgn_base[r*ADDR_W +: ADDR_W]) & rgn_mask[r*ADDR_W +: ADDR_W]) == '0);
    end

    // Scan from highest to lowest so the lowest matching window wins
    always_comb begin
        hit    = 1'b0;
        hit_fc = 1'b0;
        hit_io = '0;
        for (int i = NUM_REG - 1; i >= 0; i--) begin
            if (m[i]) begin
                hit    = 1'b1;
                hit_fc = rgn_fc[i];
                hit_io = rgn_io_sel[i*IO_W +: IO_W];
            end
        end
    end

endmodule

// File: rtl/tgt_route_dec.sv
// Request target decoder (top).
// Picks a destination node ID for each request: side-band classes go to the
// miscellaneous node; memory traffic goes to a fully coherent partition
// (by hash and table), to a selected I/O home node, or to I/O home node 0.
// The result is registered: one cycle of latency, held while idle.
// Assumes configuration inputs are stable while req_vld is high, and that
// NUM_HNI is a power of two.
module tgt_route_dec
    import tgt_route_pkg::*;
#(
    parameter int ADDR_W  = 48,
    parameter int NODE_W  = 11,
    parameter int NUM_REG = 8,
    parameter int NUM_HNI = 4,
    parameter int PART_W  = 3,
    localparam int NUM_HNF = 1 << PART_W,
    localparam int IO_W    = (NUM_HNI > 1) ? $clog2(NUM_HNI) : 1,
    localparam int LG_W    = $clog2(PART_W + 1),
    localparam int LINE_W  = ADDR_W - LINE_OFS
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_vld,
    input  logic [1:0]                req_cls,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [NODE_W-1:0]         own_id,
    input  logic [NUM_REG*ADDR_W-1:0] rgn_base,
    input  logic [NUM_REG*ADDR_W-1:0] rgn_mask,
    input  logic [NUM_REG-1:0]        rgn_en,
    input  logic [NUM_REG-1:0]        rgn_fc,
    input  logic [NUM_REG*IO_W-1:0]   rgn_io_sel,
    input  logic [LG_W-1:0]           hnf_lg,
    input  logic [NUM_HNF*NODE_W-1:0] hnf_id_tbl,
    input  logic [NUM_HNI*NODE_W-1:0] hni_id_tbl,
    input  logic [NODE_W-1:0]         mn_id,
    output logic                      out_vld,
    output logic [NODE_W-1:0]         tgt_id,
    output logic [NODE_W-1:0]         src_id
);

    logic              hit;
    logic              hit_fc;
    logic [IO_W-1:0]   hit_io;
    logic [PART_W-1:0] part;
    logic [NODE_W-1:0] nxt_tgt;

    tgt_rgn_match #(
        .ADDR_W (ADDR_W),
        .NUM_REG(NUM_REG),
        .IO_W   (IO_W)
    ) rgn_i (
        .addr      (req_addr),
        .rgn_base  (rgn_base),
        .rgn_mask  (rgn_mask),
        .rgn_en    (rgn_en),
        .rgn_fc    (rgn_fc),
        .rgn_io_sel(rgn_io_sel),
        .hit       (hit),
        .hit_fc    (hit_fc),
        .hit_io    (hit_io)
    );

    tgt_fold_hash #(
        .LINE_W(LINE_W),
        .PART_W(PART_W),
        .LG_W  (LG_W)
    ) hash_i (
        .line_addr(req_addr[ADDR_W-1:LINE_OFS]),
        .hnf_lg   (hnf_lg),
        .part     (part)
    );

    // Choose the destination: class override, then window kind, then default
    always_comb begin
        nxt_tgt = hni_id_tbl[NODE_W-1:0];
        if (req_cls_e'(req_cls) != CLS_MEM) begin
            nxt_tgt = mn_id;
        end else if (hit && hit_fc) begin
            nxt_tgt = hnf_id_tbl[int'(part)*NODE_W +: NODE_W];
        end else if (hit) begin
            nxt_tgt = hni_id_tbl[int'(hit_io)*NODE_W +: NODE_W];
        end
    end

    // Output register: valid follows the request, IDs load only on a request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            tgt_id  <= '0;
            src_id  <= '0;
        end else begin
            out_vld <= req_vld;
            if (req_vld) begin
                tgt_id <= nxt_tgt;
                src_id <= own_id;
            end
        end
    end

    AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) req_vld |=> out_vld); // R2
    AST_VLD_DROPS: assert property (@(posedge clk) disable iff (!rst_n) !req_vld |=> !out_vld); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !req_vld |=> ($stable(tgt_id) && $stable(src_id))); // R3
    AST_SIDE_TO_MN: assert property (@(posedge clk) disable iff (!rst_n) (req_vld && req_cls != 2'd0) |=> (tgt_id == $past(mn_id))); // R4
    AST_SRC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n) req_vld |=> (src_id == $past(own_id))); // R10

endmodule

// File: tb/tgt_route_dec_tb.sv
module tgt_route_dec_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW  = 16;
    localparam int NW  = 6;
    localparam int NR  = 4;
    localparam int NHI = 2;
    localparam int PW  = 3;
    localparam int NHF = 1 << PW;
    localparam int IOW = 1;
    localparam int LGW = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_vld = 1'b0;
    logic [1:0]        req_cls = 2'd0;
    logic [AW-1:0]     req_addr = '0;
    logic [NW-1:0]     own_id = 6'd9;
    logic [NR*AW-1:0]  rgn_base = '0;
    logic [NR*AW-1:0]  rgn_mask = '0;
    logic [NR-1:0]     rgn_en = '0;
    logic [NR-1:0]     rgn_fc = '0;
    logic [NR*IOW-1:0] rgn_io_sel = '0;
    logic [LGW-1:0]    hnf_lg = '0;
    logic [NHF*NW-1:0] hnf_id_tbl;
    logic [NHI*NW-1:0] hni_id_tbl;
    logic [NW-1:0]     mn_id = 6'd1;
    logic              out_vld;
    logic [NW-1:0]     tgt_id;
    logic [NW-1:0]     src_id;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    tgt_route_dec #(
        .ADDR_W(AW), .NODE_W(NW), .NUM_REG(NR), .NUM_HNI(NHI), .PART_W(PW)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_cls(req_cls),
        .req_addr(req_addr), .own_id(own_id), .rgn_base(rgn_base),
        .rgn_mask(rgn_mask), .rgn_en(rgn_en), .rgn_fc(rgn_fc),
        .rgn_io_sel(rgn_io_sel), .hnf_lg(hnf_lg), .hnf_id_tbl(hnf_id_tbl),
        .hni_id_tbl(hni_id_tbl), .mn_id(mn_id), .out_vld(out_vld),
        .tgt_id(tgt_id), .src_id(src_id)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Partition number by repeated chunk folding of the line address
    function automatic int exp_part(input int addr, input int lg);
        int line = addr >> 6;
        int h = 0;
        if (lg == 0) return 0;
        while (line != 0) begin
            h = h ^ (line & ((1 << lg) - 1));
            line = line >> lg;
        end
        return h;
    endfunction

    function automatic int exp_route(input int cls, input int addr);
        if (cls != 0) return int'(mn_id);
        for (int i = 0; i < NR; i++) begin
            int b = int'(rgn_base[i*AW +: AW]);
            int m = int'(rgn_mask[i*AW +: AW]);
            if (rgn_en[i] && (((addr ^ b) & m) == 0)) begin
                if (rgn_fc[i]) return int'(hnf_id_tbl[exp_part(addr, int'(hnf_lg))*NW +: NW]);
                return int'(hni_id_tbl[int'(rgn_io_sel[i])*NW +: NW]);
            end
        end
        return int'(hni_id_tbl[NW-1:0]);
    endfunction

    task automatic send(input int c, input int a, input string tag);
        int exp;
        @(negedge clk);
        req_vld  = 1'b1;
        req_cls  = 2'(c);
        req_addr = AW'(a);
        exp = exp_route(c, a);
        @(negedge clk);
        req_vld = 1'b0;
        chk({tag, " R2 valid"}, int'(out_vld), 1);
        chk(tag, int'(tgt_id), exp);
    endtask

    task automatic set_rgn(input int i, input int b, input int m, input bit en, input bit fc, input bit io);
        rgn_base[i*AW +: AW] = AW'(b);
        rgn_mask[i*AW +: AW] = AW'(m);
        rgn_en[i]     = en;
        rgn_fc[i]     = fc;
        rgn_io_sel[i] = io;
    endtask

    initial begin
        for (int j = 0; j < NHF; j++) hnf_id_tbl[j*NW +: NW] = NW'(20 + j);
        hni_id_tbl[0 +: NW]  = 6'd3;
        hni_id_tbl[NW +: NW] = 6'd5;

        // R1: state while reset is held
        repeat (3) @(negedge clk);
        chk("R1 out_vld", int'(out_vld), 0);
        chk("R1 tgt_id", int'(tgt_id), 0);
        chk("R1 src_id", int'(src_id), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 idle after reset", int'(out_vld), 0);

        // R5 R6: full line-address sweep for each partition count
        set_rgn(0, 0, 0, 1'b1, 1'b1, 1'b0);
        for (int lg = 0; lg <= 3; lg++) begin
            hnf_lg = LGW'(lg);
            for (int ln = 0; ln < (1 << (AW - 6)); ln++) begin
                send(0, (ln << 6) | ((ln * 7 + lg) & 63), "R5 R6 hash sweep");
            end
        end

        // R7 R8 R9: overlapping, shadowed and disabled windows
        hnf_lg = 2'd2;
        set_rgn(0, 16'h4000, 16'hC000, 1'b1, 1'b0, 1'b1);
        set_rgn(1, 16'h4000, 16'hE000, 1'b1, 1'b1, 1'b0);
        set_rgn(2, 16'h8000, 16'hC000, 1'b1, 1'b1, 1'b0);
        set_rgn(3, 16'hC000, 16'hC000, 1'b0, 1'b1, 1'b1);
        for (int a = 0; a < (1 << AW); a += 16'h0100) begin
            send(0, a + (a >> 10), "R7 R8 R9 window sweep");
        end
        send(0, 16'h4080, "R7 lowest window wins");
        send(0, 16'h0040, "R9 no match default");
        send(0, 16'hC123, "R9 disabled window");

        // R4: side-band classes ignore windows
        for (int c = 1; c <= 3; c++) begin
            for (int a = 0; a < (1 << AW); a += 16'h1357) begin
                send(c, a, "R4 class override");
            end
        end

        // R3: idle inputs change, outputs hold
        send(0, 16'h8040, "R3 setup");
        @(negedge clk);
        req_cls = 2'd1; req_addr = 16'h4000; own_id = 6'd33;
        @(negedge clk);
        chk("R3 tgt hold", int'(tgt_id), exp_route(0, 16'h8040));
        chk("R3 src hold", int'(src_id), 9);
        chk("R2 no valid while idle", int'(out_vld), 0);

        // R2 R10: back-to-back requests with different own IDs
        @(negedge clk);
        req_vld = 1'b1; req_cls = 2'd0; req_addr = 16'h4010; own_id = 6'd12;
        @(negedge clk);
        chk("R2 b2b first valid", int'(out_vld), 1);
        chk("R8 b2b first tgt", int'(tgt_id), 5);
        chk("R10 b2b first src", int'(src_id), 12);
        req_cls = 2'd2; req_addr = 16'h0000; own_id = 6'd13;
        @(negedge clk);
        req_vld = 1'b0;
        chk("R2 b2b second valid", int'(out_vld), 1);
        chk("R4 b2b second tgt", int'(tgt_id), 1);
        chk("R10 b2b second src", int'(src_id), 13);
        @(negedge clk);
        chk("R2 valid drops", int'(out_vld), 0);

        // R1: reset mid-run clears held outputs
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 re-reset valid", int'(out_vld), 0);
        chk("R1 re-reset tgt", int'(tgt_id), 0);
        chk("R1 re-reset src", int'(src_id), 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule